// File: doc/BRIEF.md
# Standby RAM Lock Controller

This block sits in front of a 16 KB standby data RAM. Software locks the RAM before the supply is switched into or out of power-down mode, so that no stray access can disturb the contents during the transition. The block holds one control register on a simple request/response register bus. It also watches the memory-access port that leads to the RAM. While the RAM is unlocked, accesses pass straight through. While it is locked, they are stopped and answered with an error.

Locking takes one register write that carries a fixed two-field pattern. Unlocking is harder on purpose: three key writes in a row must arrive in a fixed order. Any stray register write or RAM access during that sequence sends it back to the first step. A register read returns the lock flag and the current step of the unlock sequence.

The asynchronous active-low reset is released through a two-stage synchronizer. The block therefore leaves reset two clock edges after `rst_ni` rises. It comes out of reset unlocked.

Top module: `standby_ram_guard`

## Requirements
- R1: After reset the RAM is unlocked and the unlock step is 0. `reg_rdy`, `reg_err`, `mem_rdy` and `mem_err` are low.
- R2: A register write to offset 0 locks the RAM from the next cycle, provided write data bits [1:0] equal 2'b10 and bits [3:2] equal 2'b01 in that same write.
- R3: While unlocked, a write to offset 0 with any other value in bits [3:0] leaves the RAM unlocked, whatever the key field holds.
- R4: While locked, three writes to offset 0 unlock the RAM after the third. Their key field, bits [15:8], must hold 8'hA5, then 8'h5A, then 8'hC3. Each correct key advances the step by one (0, 1, 2).
- R5: While locked, a write to offset 0 whose key does not match the current step's key returns the step to 0 and keeps the lock.
- R6: While locked, any RAM access returns the step to 0 and keeps the lock. This applies even when a correct key write arrives in the same cycle.
- R7: While locked, a RAM access does not raise `ram_req`. It is answered one cycle later with `mem_err` high, `mem_rdy` low and `mem_rdata` zero.
- R8: While unlocked, a RAM access drives `ram_req`, `ram_we`, `ram_addr` and `ram_wdata` in the same cycle. It is answered one cycle later with `mem_rdy` high and `mem_rdata` equal to the RAM's read data.
- R9: A register read of offset 0 is answered one cycle later with `reg_rdy`. `reg_rdata` then has bit 16 set to the lock flag, bits [18:17] set to the unlock step, and all other bits zero.
- R10: A register access to any offset other than 0 is answered one cycle later with `reg_err`, leaves the lock and the step unchanged, and returns zero data.
- R11: A register read does not disturb the unlock sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_req | input | 1 | Register access request |
| reg_we | input | 1 | Register write (1) or read (0) |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| reg_rdy | output | 1 | Register access completed |
| reg_err | output | 1 | Register access rejected |
| mem_req | input | 1 | RAM access request |
| mem_we | input | 1 | RAM write (1) or read (0) |
| mem_addr | input | 12 | RAM word address |
| mem_wdata | input | 32 | RAM write data |
| mem_rdata | output | 32 | RAM read data returned to the requester |
| mem_rdy | output | 1 | RAM access completed |
| mem_err | output | 1 | RAM access refused (locked) |
| ram_req | output | 1 | Request forwarded to the RAM |
| ram_we | output | 1 | Write enable forwarded to the RAM |
| ram_addr | output | 12 | Address forwarded to the RAM |
| ram_wdata | output | 32 | Write data forwarded to the RAM |
| ram_rdata | input | 32 | Read data from the RAM, valid the cycle after a request |

## Verification
The bench aims at the unlock sequence. It sends a correct key followed by a wrong one, a repeated first key, a read in the middle of the sequence, and a RAM access in the same cycle as the final correct key. A design that advanced on a wrong key, let reads reset the step, or let the key write beat the access would unlock the RAM too early or too late. It also writes near-miss lock patterns: only one field right, or the two fields swapped. A design that checked only one field would lock when it must not. Accesses made while locked are checked for a silent `ram_req` and zeroed data, which catches a gate that leaks RAM contents. Writes to a wrong offset carrying correct keys catch a decoder that ignores the address.

// File: rtl/srg_pkg.sv
package srg_pkg;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned REG_AW    = 4;
  localparam int unsigned RAM_BYTES = 16384;
  localparam int unsigned MEM_AW    = $clog2(RAM_BYTES / (DATA_W / 8));

  localparam logic [REG_AW-1:0] CTRL_OFS = '0;

  // lock pattern fields
  localparam int unsigned FA_LSB = 0;
  localparam int unsigned FB_LSB = 2;
  localparam logic [1:0]  FA_LOCK = 2'b10;
  localparam logic [1:0]  FB_LOCK = 2'b01;

  // unlock key field and sequence
  localparam int unsigned KEY_LSB  = 8;
  localparam int unsigned NUM_KEYS = 3;
  localparam int unsigned STEP_W   = $clog2(NUM_KEYS);

  // status fields on read
  localparam int unsigned STAT_LOCK_BIT = 16;
  localparam int unsigned STAT_STEP_LSB = 17;

  function automatic logic [7:0] key_for(input logic [STEP_W-1:0] step);
    case (step)
      0:       key_for = 8'hA5;
      1:       key_for = 8'h5A;
      default: key_for = 8'hC3;
    endcase
  endfunction
endpackage

// File: rtl/srg_rst_sync.sv
module srg_rst_sync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/srg_regbank.sv
module srg_regbank
  import srg_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned AW = REG_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_req,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  input  logic          mem_req,
  output logic [DW-1:0] reg_rdata,
  output logic          reg_rdy,
  output logic          reg_err,
  output logic          locked_o
);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_KEYS - 1);

  logic              locked_q, locked_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic              rdy_d, err_d;
  logic [DW-1:0]     rdata_d;
  logic              addr_ok, wr_hit, pat_ok, key_ok, state_en;
  logic [7:0]        key_in;

  assign addr_ok  = (reg_addr == CTRL_OFS);
  assign wr_hit   = reg_req && reg_we && addr_ok;
  assign pat_ok   = (reg_wdata[FA_LSB +: 2] == FA_LOCK) &&
                    (reg_wdata[FB_LSB +: 2] == FB_LOCK);
  assign key_in   = reg_wdata[KEY_LSB +: 8];
  assign key_ok   = (key_in == key_for(step_q));
  assign state_en = wr_hit || mem_req;

  // next state of lock and unlock sequence
  always_comb begin
    locked_d = locked_q;
    step_d   = step_q;
    if (locked_q) begin
      if (mem_req) begin
        step_d = '0;
      end else if (wr_hit) begin
        if (!key_ok) begin
          step_d = '0;
        end else if (step_q == LAST_STEP) begin
          locked_d = 1'b0;
          step_d   = '0;
        end else begin
          step_d = step_q + 1'b1;
        end
      end
    end else if (wr_hit && pat_ok) begin
      locked_d = 1'b1;
      step_d   = '0;
    end
  end

  // next response
  always_comb begin
    rdy_d   = reg_req && addr_ok;
    err_d   = reg_req && !addr_ok;
    rdata_d = '0;
    if (reg_req && !reg_we && addr_ok) begin
      rdata_d[STAT_LOCK_BIT]             = locked_q;
      rdata_d[STAT_STEP_LSB +: STEP_W]   = step_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q <= 1'b0;
      step_q   <= '0;
    end else if (state_en) begin
      locked_q <= locked_d;
      step_q   <= step_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdy   <= 1'b0;
      reg_err   <= 1'b0;
      reg_rdata <= '0;
    end else begin
      reg_rdy   <= rdy_d;
      reg_err   <= err_d;
      reg_rdata <= rdata_d;
    end
  end

  assign locked_o = locked_q;

  // R2: the lock is only entered through a pattern write
  p_lock_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_q) |-> $past(wr_hit && pat_ok));

  // R4: the lock is only left through the final key with no access pending
  p_unlock_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked_q) |-> $past(wr_hit && !mem_req && step_q == LAST_STEP &&
                              key_in == 8'hC3));

  // R5: the sequence step is idle whenever unlocked
  p_step_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !locked_q |-> step_q == '0);

  // R6: a RAM access while locked restarts the sequence
  p_access_breaks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && mem_req) |=> (step_q == '0 && locked_q));

  // R9, R10: each register request gets exactly one kind of answer
  p_reg_answer_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req |=> (reg_rdy ^ reg_err));

  // R11: a read never moves the lock state
  p_read_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && !reg_we && !mem_req) |=> ($stable(step_q) && $stable(locked_q)));
endmodule

// File: rtl/srg_access_gate.sv
module srg_access_gate
  import srg_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned AW = MEM_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          locked,
  input  logic          mem_req,
  input  logic          mem_we,
  input  logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_wdata,
  output logic [DW-1:0] mem_rdata,
  output logic          mem_rdy,
  output logic          mem_err,
  output logic          ram_req,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output logic [DW-1:0] ram_wdata,
  input  logic [DW-1:0] ram_rdata
);
  logic pass, rdy_d, err_d;

  assign pass      = mem_req && !locked;
  assign ram_req   = pass;
  assign ram_we    = pass && mem_we;
  assign ram_addr  = mem_addr;
  assign ram_wdata = mem_wdata;

  always_comb begin
    rdy_d = pass;
    err_d = mem_req && locked;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_rdy <= 1'b0;
      mem_err <= 1'b0;
    end else begin
      mem_rdy <= rdy_d;
      mem_err <= err_d;
    end
  end

  assign mem_rdata = mem_rdy ? ram_rdata : '0;

  // R7: a locked access is refused with no data returned
  p_locked_refused_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && locked) |=> (mem_err && !mem_rdy && mem_rdata == '0));

  // R8: an unlocked access completes on the next cycle
  p_open_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !locked) |=> (mem_rdy && !mem_err));
endmodule

// File: rtl/standby_ram_guard.sv
module standby_ram_guard
  import srg_pkg::*;
#(
  parameter int unsigned DW  = DATA_W,
  parameter int unsigned RAW = REG_AW,
  parameter int unsigned MAW = MEM_AW
) (
  input  logic           clk,
  input  logic           rst_ni,
  input  logic           reg_req,
  input  logic           reg_we,
  input  logic [RAW-1:0] reg_addr,
  input  logic [DW-1:0]  reg_wdata,
  output logic [DW-1:0]  reg_rdata,
  output logic           reg_rdy,
  output logic           reg_err,
  input  logic           mem_req,
  input  logic           mem_we,
  input  logic [MAW-1:0] mem_addr,
  input  logic [DW-1:0]  mem_wdata,
  output logic [DW-1:0]  mem_rdata,
  output logic           mem_rdy,
  output logic           mem_err,
  output logic           ram_req,
  output logic           ram_we,
  output logic [MAW-1:0] ram_addr,
  output logic [DW-1:0]  ram_wdata,
  input  logic [DW-1:0]  ram_rdata
);
  logic rst_n;
  logic locked;

  srg_rst_sync u_rst (.clk(clk), .rst_ni(rst_ni), .rst_no(rst_n));

  srg_regbank #(.DW(DW), .AW(RAW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .mem_req(mem_req),
    .reg_rdata(reg_rdata), .reg_rdy(reg_rdy), .reg_err(reg_err),
    .locked_o(locked)
  );

  srg_access_gate #(.DW(DW), .AW(MAW)) u_gate (
    .clk(clk), .rst_n(rst_n), .locked(locked),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_rdy(mem_rdy), .mem_err(mem_err),
    .ram_req(ram_req), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
  );
endmodule

// File: tb/tb_standby_ram_guard.sv
module tb_standby_ram_guard;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic        reg_req, reg_we;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        reg_rdy, reg_err;
  logic        mem_req, mem_we;
  logic [11:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic        mem_rdy, mem_err;
  logic        ram_req, ram_we;
  logic [11:0] ram_addr;
  logic [31:0] ram_wdata, ram_rdata;

  int checks = 0;
  int errors = 0;
  bit m_locked;
  int m_step;

  always #2.5 clk = ~clk;

  standby_ram_guard dut (.*);

  function automatic logic [31:0] ram_f(input logic [11:0] a);
    return {a, 8'h3C, a} ^ 32'h0BAD_F00D;
  endfunction

  always @(posedge clk) if (ram_req) ram_rdata <= ram_f(ram_addr);

  function automatic logic [7:0] exp_key(input int s);
    return (s == 0) ? 8'hA5 : (s == 1) ? 8'h5A : 8'hC3;
  endfunction

  function automatic logic [31:0] mk(input logic [7:0] key, input logic [1:0] fb,
                                     input logic [1:0] fa);
    return {16'h0, key, 4'h0, fb, fa};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // model update for a write (acc = RAM access in the same cycle)
  task automatic model_wr(input logic [3:0] a, input logic [31:0] d, input bit acc);
    if (m_locked) begin
      if (acc) m_step = 0;
      else if (a == 4'd0) begin
        if (d[15:8] != exp_key(m_step)) m_step = 0;
        else if (m_step == 2) begin m_locked = 0; m_step = 0; end
        else m_step++;
      end
    end else if (a == 4'd0 && d[1:0] == 2'b10 && d[3:2] == 2'b01) begin
      m_locked = 1; m_step = 0;
    end
  endtask

  task automatic reg_write(input logic [3:0] a, input logic [31:0] d, input string req);
    @(negedge clk);
    reg_req = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    chk(reg_rdy == (a == 0) && reg_err == (a != 0), req, {reg_rdy, reg_err}, {a == 0, a != 0});
    model_wr(a, d, 0);
    @(negedge clk); reg_req = 0; reg_we = 0;
  endtask

  task automatic reg_read(input logic [3:0] a, input string req);
    logic [31:0] e;
    @(negedge clk);
    reg_req = 1; reg_we = 0; reg_addr = a;
    e = (a == 0) ? (32'(m_locked) << 16) | (32'(m_step) << 17) : 32'h0;
    @(posedge clk); #1;
    chk(reg_rdata == e && reg_err == (a != 0), req, reg_rdata, e);
    @(negedge clk); reg_req = 0;
  endtask

  task automatic mem_access(input bit we, input logic [11:0] a, input string req,
                            input bit with_wr, input logic [31:0] wd);
    bit was_locked = m_locked;
    @(negedge clk);
    mem_req = 1; mem_we = we; mem_addr = a; mem_wdata = {20'h0, a};
    if (with_wr) begin reg_req = 1; reg_we = 1; reg_addr = 0; reg_wdata = wd; end
    #1;
    chk(ram_req == !was_locked && (was_locked || (ram_addr == a && ram_we == we)),
        req, {ram_req, ram_we, 18'h0, ram_addr}, {!was_locked, we, 18'h0, a});
    @(posedge clk); #1;
    if (was_locked)
      chk(mem_err && !mem_rdy && mem_rdata == 0, req, {mem_err, mem_rdy, mem_rdata[29:0]}, 32'h8000_0000);
    else
      chk(mem_rdy && !mem_err && mem_rdata == ram_f(a), req, mem_rdata, ram_f(a));
    if (with_wr) model_wr(0, wd, 1);
    else if (m_locked) m_step = 0;
    @(negedge clk); mem_req = 0; reg_req = 0; reg_we = 0;
  endtask

  task automatic unlock_all(input string req);
    reg_write(0, mk(8'hA5, 0, 0), req);
    reg_write(0, mk(8'h5A, 0, 0), req);
    reg_write(0, mk(8'hC3, 0, 0), req);
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_ni = 0; reg_req = 0; reg_we = 0; reg_addr = 0; reg_wdata = 0;
    mem_req = 0; mem_we = 0; mem_addr = 0; mem_wdata = 0;
    m_locked = 0; m_step = 0;
    repeat (3) @(posedge clk);
    #1;
    chk(!reg_rdy && !reg_err && !mem_rdy && !mem_err, "R1",
        {reg_rdy, reg_err, mem_rdy, mem_err}, 0);
    @(negedge clk); rst_ni = 1;
    repeat (3) @(posedge clk);
    reg_read(0, "R1");

    // R3 near-miss patterns, R8 open access
    reg_write(0, mk(8'hA5, 2'b01, 2'b01), "R3");
    reg_write(0, mk(8'h00, 2'b10, 2'b10), "R3");
    reg_write(0, mk(8'hFF, 2'b10, 2'b01), "R3");
    reg_read(0, "R3");
    mem_access(1, 12'h123, "R8", 0, 0);
    // R10 wrong offset cannot lock
    reg_write(4'd5, mk(0, 2'b01, 2'b10), "R10");
    reg_read(0, "R10");
    reg_read(4'd7, "R10");
    // R2 lock
    reg_write(0, mk(0, 2'b01, 2'b10), "R2");
    reg_read(0, "R2");
    mem_access(0, 12'hFFF, "R7", 0, 0);
    // R5 wrong key after correct one, repeated first key
    reg_write(0, mk(8'hA5, 0, 0), "R5");
    reg_write(0, mk(8'hA5, 0, 0), "R5");
    reg_read(0, "R5");
    // R11 read mid-sequence, R10 wrong offset mid-sequence
    reg_write(0, mk(8'hA5, 0, 0), "R11");
    reg_read(0, "R11");
    reg_write(4'd3, mk(8'h5A, 0, 0), "R10");
    reg_write(0, mk(8'h5A, 0, 0), "R11");
    reg_read(0, "R11");
    // R6 access in the same cycle as the final key
    mem_access(0, 12'h010, "R6", 1, mk(8'hC3, 0, 0));
    reg_read(0, "R6");
    // R4 full unlock
    unlock_all("R4");
    reg_read(0, "R4");
    mem_access(0, 12'h055, "R4", 0, 0);

    // random phase
    for (int i = 0; i < 600; i++) begin
      int op = $urandom_range(0, 7);
      case (op)
        0: reg_write(0, mk(8'($urandom), 2'b01, 2'b10), "R2");
        1: reg_write(0, {16'h0, 8'($urandom), 4'h0, 4'($urandom)}, "R3");
        2, 3: reg_write(0, mk(($urandom_range(0, 3) != 0) ? exp_key(m_step) : 8'($urandom), 0, 0), "R4");
        4: reg_read(0, "R9");
        5: mem_access(1'($urandom), 12'($urandom), m_locked ? "R7" : "R8", 0, 0);
        6: reg_write(4'($urandom_range(1, 15)), 32'($urandom), "R10");
        default: begin
          reg_read(0, "R11");
          reg_read(0, "R9");
        end
      endcase
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule